// File: doc/BRIEF.md
# Store Address and Data Formatter

This unit turns one decoded fixed-point store into one write request for a 64-bit data bus. The operation arrives with the base, index and source operand values, a flag that says the base register field is zero, a 16-bit displacement and control bits for access size, indexed addressing, base update and byte reversal. One clock later the unit presents the effective address, the write data already moved onto the byte lanes it occupies, the matching byte enables, an optional base-register writeback value and an illegal-form flag.

The address is a base term plus either the sign-extended displacement or the full index value. A non-update store with a zero base field uses the constant zero as its base term. An update store always uses the real base value and hands the effective address back for the base register. Doubleword stores in displacement form clear the two lowest displacement bits, so their offset is always a multiple of four. Byte-reversed stores are only legal for indexed halfword, word and doubleword accesses without update. Nothing in the unit keeps condition or status state.

Top module: `store_fmt`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high and low otherwise; all other outputs are registered in that same edge.
- R3: For a non-update store the base term is zero when `base_zero` is high and `base_val` otherwise.
- R4: With `indexed` low the offset is `disp` sign-extended to 64 bits; with `indexed` high it is `index_val`, and `disp` has no effect.
- R5: For a doubleword (`acc_size` = 3) with `indexed` low, bits 1:0 of `disp` are treated as zero before sign extension.
- R6: `acc_size` 0, 1, 2, 3 selects 1, 2, 4 or 8 bytes, taken from the least significant bytes of `src_val`.
- R7: The selected bytes are shifted left by 8 times `ea[2:0]` bit positions in `wdata`, and `byte_en` is the mask of those byte positions on lanes 0 to 7 (lane 0 = `wdata[7:0]`); bytes that would fall above lane 7 are dropped.
- R8: For an update store that is legal, `wb_valid` is high and `wb_value` equals `ea`, computed from `base_val` even if `base_zero` is set; otherwise `wb_valid` and `wb_value` are zero.
- R9: An update store with `base_zero` high raises `illegal`; a request with `illegal` high has `byte_en`, `wdata`, `wb_valid` and `wb_value` all zero, while `ea` is still reported.
- R10: With `reverse` high, the selected bytes are written in reversed order (byte k of the payload is source byte n-1-k for n bytes); `reverse` combined with a byte access, with `indexed` low or with `update` high raises `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Store operation present this cycle |
| base_val | input | 64 | Base register contents |
| base_zero | input | 1 | Base register field is zero |
| index_val | input | 64 | Index register contents |
| src_val | input | 64 | Source register contents |
| disp | input | 16 | Displacement field |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| indexed | input | 1 | Use index register instead of displacement |
| update | input | 1 | Write effective address back to base register |
| reverse | input | 1 | Byte-reversed store |
| out_valid | output | 1 | Result present |
| ea | output | 64 | Effective address |
| wdata | output | 64 | Lane-aligned write data |
| byte_en | output | 8 | Byte enables, bit i for lane i |
| wb_valid | output | 1 | Base register writeback requested |
| wb_value | output | 64 | Value for the base register |
| illegal | output | 1 | Invalid instruction form, no write |

## Verification
Stores are applied with a zero base field in both update and non-update form, which separates zero substitution from the update path and from the illegal check. Negative displacements, doubleword displacements with nonzero low bits and indexed forms with a nonzero displacement tell apart sign extension, offset scaling and source selection of the offset. Every access size is placed on aligned and unaligned lanes, including accesses that run past lane 7, and reversed stores of each width are mixed with the three illegal reversal combinations. A back-to-back stream followed by pseudo-random operations checks that each result appears exactly one cycle after its request.

// File: rtl/store_fmt_pkg.sv
package store_fmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // number of bytes moved by an access size
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction

endpackage

// File: rtl/store_fmt_addr.sv
module store_fmt_addr #(
  parameter int XLEN    = 64,
  parameter int DISP_W  = 16,
  parameter int DS_ZERO = 2
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic              base_zero,
  input  logic              update,
  input  logic [XLEN-1:0]   index_val,
  input  logic              indexed,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        acc_size,
  output logic [XLEN-1:0]   ea
);
  import store_fmt_pkg::*;

  localparam logic [DISP_W-1:0] LOW_CLR = {{(DISP_W-DS_ZERO){1'b1}}, {DS_ZERO{1'b0}}};

  logic [XLEN-1:0]   base_term;
  logic [DISP_W-1:0] disp_eff;
  logic [XLEN-1:0]   offset;

  always_comb begin
    // update forms never substitute zero for the base
    if (base_zero && !update) base_term = '0;
    else                      base_term = base_val;

    if (acc_size == SZ_DWORD) disp_eff = disp & LOW_CLR;
    else                      disp_eff = disp;

    if (indexed) offset = index_val;
    else         offset = {{(XLEN-DISP_W){disp_eff[DISP_W-1]}}, disp_eff};

    ea = base_term + offset;
  end

endmodule

// File: rtl/store_fmt_legal.sv
module store_fmt_legal (
  input  logic [1:0] acc_size,
  input  logic       indexed,
  input  logic       update,
  input  logic       reverse,
  input  logic       base_zero,
  output logic       illegal
);
  import store_fmt_pkg::*;

  logic bad_update;
  logic bad_reverse;

  always_comb begin
    bad_update  = update && base_zero;
    bad_reverse = reverse && ((acc_size == SZ_BYTE) || !indexed || update);
    illegal     = bad_update || bad_reverse;
  end

endmodule

// File: rtl/store_fmt_lane.sv
module store_fmt_lane #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]           src_val,
  input  logic [1:0]                acc_size,
  input  logic                      reverse,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic                      kill,
  output logic [XLEN-1:0]           wdata,
  output logic [XLEN/8-1:0]         byte_en
);
  import store_fmt_pkg::*;

  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);

  logic [7:0]      src_b [NB];
  logic [7:0]      pay_b [NB];
  logic [XLEN-1:0] payload;
  logic [NB-1:0]   mask;
  int unsigned     nbytes;

  for (genvar g = 0; g < NB; g++) begin : g_split
    assign src_b[g] = src_val[8*g +: 8];
    assign payload[8*g +: 8] = pay_b[g];
  end

  always_comb begin
    nbytes = size_bytes(acc_size);
    for (int i = 0; i < NB; i++) begin
      mask[i]  = (i < int'(nbytes));
      pay_b[i] = 8'h00;
      if (i < int'(nbytes)) begin
        if (reverse) pay_b[i] = src_b[int'(nbytes) - 1 - i];
        else         pay_b[i] = src_b[i];
      end
    end
  end

  always_comb begin
    if (kill) begin
      wdata   = '0;
      byte_en = '0;
    end else begin
      wdata   = payload << {lane, 3'b000};
      byte_en = mask << lane;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, LANE_W[0]};

endmodule

// File: rtl/store_fmt.sv
module store_fmt #(
  parameter int XLEN    = 64,
  parameter int DISP_W  = 16,
  parameter int DS_ZERO = 2,
  parameter int NB      = XLEN / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   base_val,
  input  logic              base_zero,
  input  logic [XLEN-1:0]   index_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        acc_size,
  input  logic              indexed,
  input  logic              update,
  input  logic              reverse,
  output logic              out_valid,
  output logic [XLEN-1:0]   ea,
  output logic [XLEN-1:0]   wdata,
  output logic [NB-1:0]     byte_en,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_value,
  output logic              illegal
);

  localparam int LANE_W = $clog2(NB);

  logic [XLEN-1:0] ea_c;
  logic [XLEN-1:0] wdata_c;
  logic [NB-1:0]   be_c;
  logic            ill_c;
  logic            wbv_c;

  store_fmt_addr #(.XLEN(XLEN), .DISP_W(DISP_W), .DS_ZERO(DS_ZERO)) u_addr (
    .base_val  (base_val),
    .base_zero (base_zero),
    .update    (update),
    .index_val (index_val),
    .indexed   (indexed),
    .disp      (disp),
    .acc_size  (acc_size),
    .ea        (ea_c)
  );

  store_fmt_legal u_legal (
    .acc_size  (acc_size),
    .indexed   (indexed),
    .update    (update),
    .reverse   (reverse),
    .base_zero (base_zero),
    .illegal   (ill_c)
  );

  store_fmt_lane #(.XLEN(XLEN)) u_lane (
    .src_val  (src_val),
    .acc_size (acc_size),
    .reverse  (reverse),
    .lane     (ea_c[LANE_W-1:0]),
    .kill     (ill_c),
    .wdata    (wdata_c),
    .byte_en  (be_c)
  );

  assign wbv_c = update && !ill_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      wdata     <= '0;
      byte_en   <= '0;
      wb_valid  <= 1'b0;
      wb_value  <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea       <= ea_c;
        wdata    <= wdata_c;
        byte_en  <= be_c;
        wb_valid <= wbv_c;
        wb_value <= wbv_c ? ea_c : '0;
        illegal  <= ill_c;
      end else begin
        wb_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/store_fmt_chk.sv
module store_fmt_chk #(
  parameter int XLEN = 64,
  parameter int NB   = XLEN / 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] base_val,
  input logic            base_zero,
  input logic [1:0]      acc_size,
  input logic            indexed,
  input logic            update,
  input logic            reverse,
  input logic            out_valid,
  input logic [XLEN-1:0] ea,
  input logic [NB-1:0]   byte_en,
  input logic            wb_valid,
  input logic [XLEN-1:0] wb_value,
  input logic            illegal
);
  localparam int LANE_W = $clog2(NB);

  AST_OUT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_UPD_ZERO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    in_valid && update && base_zero |=> illegal); // R9

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && illegal |-> (byte_en == '0) && !wb_valid); // R9

  AST_WB_MATCH_EA: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> out_valid && (wb_value == ea)); // R8

  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !illegal |-> byte_en[ea[LANE_W-1:0]]); // R7

  AST_REV_BYTE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    in_valid && reverse && (acc_size == 2'd0) |=> illegal); // R10

  AST_DWORD_DISP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && !indexed && (acc_size == 2'd3) && !base_zero
    |=> ea[1:0] == $past(base_val[1:0])); // R5

endmodule

bind store_fmt store_fmt_chk #(.XLEN(XLEN), .NB(NB)) u_store_fmt_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .base_val  (base_val),
  .base_zero (base_zero),
  .acc_size  (acc_size),
  .indexed   (indexed),
  .update    (update),
  .reverse   (reverse),
  .out_valid (out_valid),
  .ea        (ea),
  .byte_en   (byte_en),
  .wb_valid  (wb_valid),
  .wb_value  (wb_value),
  .illegal   (illegal)
);

// File: tb/test_store_fmt.sv
module test_store_fmt;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] base_val = '0;
  logic        base_zero = 1'b0;
  logic [63:0] index_val = '0;
  logic [63:0] src_val = '0;
  logic [15:0] disp = '0;
  logic [1:0]  acc_size = '0;
  logic        indexed = 1'b0;
  logic        update = 1'b0;
  logic        reverse = 1'b0;
  logic        out_valid;
  logic [63:0] ea, wdata, wb_value;
  logic [7:0]  byte_en;
  logic        wb_valid, illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] ea;
    logic [63:0] wdata;
    logic [7:0]  be;
    logic        wbv;
    logic [63:0] wbd;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  store_fmt i_store_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
    .base_zero(base_zero), .index_val(index_val), .src_val(src_val),
    .disp(disp), .acc_size(acc_size), .indexed(indexed), .update(update),
    .reverse(reverse), .out_valid(out_valid), .ea(ea), .wdata(wdata),
    .byte_en(byte_en), .wb_valid(wb_valid), .wb_value(wb_value),
    .illegal(illegal)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic [63:0] b, input logic bz,
      input logic [63:0] x, input logic [63:0] s, input logic [15:0] d,
      input logic [1:0] sz, input logic ix, input logic up, input logic rv,
      input string tag);
    exp_t e;
    logic [63:0] bterm, off, pay;
    logic [15:0] dd;
    logic [15:0] m16;
    int n;
    int lane;
    bterm = (bz && !up) ? 64'd0 : b;               // R3
    dd = (sz == 2'd3) ? {d[15:2], 2'b00} : d;      // R5
    off = ix ? x : {{48{dd[15]}}, dd};             // R4
    e.ea = bterm + off;
    e.ill = (up && bz) || (rv && (sz == 2'd0 || !ix || up)); // R9 R10
    n = 1 << sz;                                   // R6
    pay = '0;
    for (int k = 0; k < n; k++)
      pay[8*k +: 8] = rv ? s[8*(n-1-k) +: 8] : s[8*k +: 8];
    lane = int'(e.ea[2:0]);                        // R7
    m16 = ((16'd1 << n) - 16'd1) << lane;
    e.wdata = e.ill ? 64'd0 : (pay << (8*lane));
    e.be = e.ill ? 8'd0 : m16[7:0];
    e.wbv = up && !e.ill;                          // R8
    e.wbd = e.wbv ? e.ea : 64'd0;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [63:0] b, input logic bz, input logic [63:0] x,
      input logic [63:0] s, input logic [15:0] d, input logic [1:0] sz,
      input logic ix, input logic up, input logic rv, input string tag);
    @(negedge clk);
    base_val = b; base_zero = bz; index_val = x; src_val = s; disp = d;
    acc_size = sz; indexed = ix; update = up; reverse = rv; in_valid = 1'b1;
    sb.push_back(model(b, bz, x, s, d, sz, ix, up, rv, tag));
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL R2 out_valid=1 with nothing outstanding, expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_checks++;
          if (ea !== e.ea || wdata !== e.wdata || byte_en !== e.be ||
              wb_valid !== e.wbv || wb_value !== e.wbd || illegal !== e.ill) begin
            n_fails++;
            $display("FAIL %s ea=%h wd=%h be=%h wbv=%b wb=%h ill=%b expected ea=%h wd=%h be=%h wbv=%b wb=%h ill=%b",
                     e.tag, ea, wdata, byte_en, wb_valid, wb_value, illegal,
                     e.ea, e.wdata, e.be, e.wbv, e.wbd, e.ill);
          end
        end
      end else if (sb.size() != 0) begin
        n_checks++; n_fails++;
        $display("FAIL R2 out_valid=0 with %0d outstanding, expected 1", sb.size());
        void'(sb.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++; n_fails++;
    $display("FAIL watchdog expired, expected run to complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_checks++;  // R1
    if (out_valid !== 1'b0 || ea !== '0 || wdata !== '0 || byte_en !== '0 ||
        wb_valid !== 1'b0 || wb_value !== '0 || illegal !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset outputs ov=%b ea=%h wd=%h be=%h, expected all 0",
               out_valid, ea, wdata, byte_en);
    end
    @(negedge clk); rst = 1'b0;

    // sizes, aligned and unaligned
    send(64'h1000, 0, 0, 64'h1122334455667788, 16'd5, 2'd0, 0, 0, 0, "R6");
    send(64'h1000, 0, 0, 64'h1122334455667788, 16'd2, 2'd1, 0, 0, 0, "R6");
    send(64'h1000, 0, 0, 64'h1122334455667788, 16'd4, 2'd2, 0, 0, 0, "R6");
    send(64'h1000, 0, 0, 64'h1122334455667788, 16'd8, 2'd3, 0, 0, 0, "R6");
    send(64'h2006, 0, 0, 64'hA1B2C3D4E5F60718, 16'd0, 2'd2, 0, 0, 0, "R7");
    send(64'h2003, 0, 0, 64'hA1B2C3D4E5F60718, 16'd0, 2'd1, 0, 0, 0, "R7");
    idle(2);
    // base zero substitution and displacement handling
    send(64'hDEAD0000, 1, 0, 64'h55, 16'h0040, 2'd0, 0, 0, 0, "R3");
    send(64'hDEAD0000, 1, 64'h300, 64'h55, 16'h7777, 2'd1, 1, 0, 0, "R3");
    send(64'h5000, 0, 0, 64'h99, 16'hFFF0, 2'd0, 0, 0, 0, "R4");
    send(64'h5000, 0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1234, 16'h1234, 2'd1, 1, 0, 0, "R4");
    send(64'h8000, 0, 0, 64'h0102030405060708, 16'h0013, 2'd3, 0, 0, 0, "R5");
    send(64'h8000, 0, 0, 64'h0102030405060708, 16'hFFFB, 2'd3, 0, 0, 0, "R5");
    send(64'h8000, 0, 0, 64'hCAFE, 16'h0003, 2'd2, 0, 0, 0, "R5");
    // update forms
    send(64'h9000, 0, 0, 64'h77, 16'h0021, 2'd0, 0, 1, 0, "R8");
    send(64'h9000, 0, 64'h18, 64'h7788, 16'h0, 2'd1, 1, 1, 0, "R8");
    send(64'h9000, 1, 0, 64'h77, 16'h0021, 2'd2, 0, 1, 0, "R9");
    send(64'h9000, 1, 64'h8, 64'h77, 16'h0, 2'd3, 1, 1, 0, "R9");
    // byte reversal
    send(64'hA000, 0, 64'h2, 64'h1122334455667788, 16'h0, 2'd1, 1, 0, 1, "R10");
    send(64'hA000, 0, 64'h4, 64'h1122334455667788, 16'h0, 2'd2, 1, 0, 1, "R10");
    send(64'hA000, 0, 64'h0, 64'h1122334455667788, 16'h0, 2'd3, 1, 0, 1, "R10");
    send(64'hA000, 0, 64'h0, 64'h1122334455667788, 16'h0, 2'd0, 1, 0, 1, "R10");
    send(64'hA000, 0, 64'h0, 64'h1122334455667788, 16'h4, 2'd2, 0, 0, 1, "R10");
    send(64'hA000, 0, 64'h4, 64'h1122334455667788, 16'h0, 2'd2, 1, 1, 1, "R10");
    idle(3);
    // back-to-back pseudo-random stream
    for (int i = 0; i < 200; i++) begin
      send({$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
           {$urandom, $urandom}, 16'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "R7");
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    n_checks++;  // R2
    if (sb.size() != 0) begin
      n_fails++;
      $display("FAIL R2 %0d results never appeared, expected 0", sb.size());
    end
    finish_run();
  end

endmodule